// File: doc/BRIEF.md
# Multi-Lane Multiframe Alignment Monitor

This block watches the received octet streams of several lanes once frame synchronisation has reached its data state. Each lane carries a multiframe-end marker, and the block uses the first such marker on every lane to work out when the lanes line up. That point gives the earliest moment at which a downstream elastic buffer can be released. The block emits a one-cycle release strobe at that moment. The buffer itself is not part of the block.

Two different lane-alignment faults are reported on separate flags. The first is a skew fault: during the initial alignment sequence, the first markers of all lanes are spread over a full multiframe or more. The second is a slip fault: once user data flows, some lane's marker appears at a place other than one multiframe after its previous marker. A per-lane mask shows which lanes slipped. The multiframe length in octets (F times K) is an input, and the number of lanes is a parameter from 1 to 8.

Top module: `lane_align_monitor`

## Requirements
- R1: While `fs_data_i` is low, the block ignores markers, does not pulse `release_o`, and drives `skew_err_o`, `align_err_o` and `slip_lanes_o` to zero from the first clock edge that samples the low level.
- R2: A marker is an octet equal to 8'h7C with its lane's control flag at 1. A control octet with another value, or 8'h7C with the control flag at 0, is not a marker.
- R3: All outputs are registered. After `fs_data_i` rises, `release_o` is high for exactly one cycle: the cycle that follows the cycle in which the last lane shows its first marker. This holds only when no skew fault has occurred.
- R4: Let t0 be the cycle of the earliest first marker. If some lane has still not shown a marker in any cycle before t0 + `mf_len_i`, then `skew_err_o` rises in the cycle after t0 + `mf_len_i`, and no release follows for that sequence.
- R5: After the release, each lane expects its marker exactly `mf_len_i` cycles after its previous marker. A marker at any other cycle raises `align_err_o` one cycle later and sets bit i of `slip_lanes_o` for lane i. Missing markers are not faults.
- R6: `skew_err_o`, `align_err_o` and the bits of `slip_lanes_o` stay set until `fs_data_i` goes low.
- R7: `mf_len_i` may be any value from 1 to 256, and the checks above hold at 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_data_i | input | 1 | Frame synchronisation is in its data state; low starts a new alignment sequence |
| lane_octet_i | input | NUM_LANES*OCTET_W | Received octet per lane, lane i in bits [i*OCTET_W +: OCTET_W] |
| lane_is_k_i | input | NUM_LANES | Control-character flag per lane |
| mf_len_i | input | MF_LEN_W | Multiframe length in octets, 1 to 256 |
| release_o | output | 1 | One-cycle buffer release strobe |
| skew_err_o | output | 1 | First markers spread over a multiframe or more |
| align_err_o | output | 1 | Marker seen off its expected position during user data |
| slip_lanes_o | output | NUM_LANES | Lanes that produced an off-position marker |

## Verification
The lanes are given fixed per-lane delays, and each pattern tests one distinction. Equal delays test the basic release. Mixed delays check that the strobe follows the latest lane and not the earliest. A spread of one multiframe minus one against exactly one multiframe separates a legal release from a skew fault at the boundary. A one-octet delay inserted on a single lane well into user data must raise the slip flag with only that lane's bit set. Lookalike characters placed before the real markers must neither start the skew window nor trigger a release. A run with a 256-octet multiframe checks the widest setting.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    // Control code that closes every multiframe
    localparam logic [7:0] MF_END_CODE = 8'h7C;

    typedef enum logic [1:0] {
        PH_COLLECT = 2'd0,
        PH_DATA    = 2'd1,
        PH_FAIL    = 2'd2
    } phase_e;

endpackage

// File: rtl/lane_mf_tracker.sv
module lane_mf_tracker #(
    parameter int OCTET_W  = 8,
    parameter int MF_LEN_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [OCTET_W-1:0]  octet,
    input  logic                is_k,
    input  logic [MF_LEN_W-1:0] mf_len,
    output logic                a_hit,
    output logic                on_bnd
);
    import lane_align_pkg::*;

    typedef struct packed {
        logic                started;
        logic [MF_LEN_W-1:0] pos;
    } trk_t;

    trk_t                trk_d, trk_q;
    logic [MF_LEN_W-1:0] last_pos;

    always_comb begin
        last_pos = mf_len - MF_LEN_W'(1);
        a_hit    = is_k && (octet == OCTET_W'(MF_END_CODE));
        on_bnd   = trk_q.started && (trk_q.pos == last_pos);

        trk_d = trk_q;
        if (clear) begin
            trk_d = '0;
        end else if (a_hit) begin
            // every marker re-anchors the lane's multiframe position
            trk_d.started = 1'b1;
            trk_d.pos     = '0;
        end else if (trk_q.started) begin
            trk_d.pos = on_bnd ? '0 : trk_q.pos + MF_LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/skew_window.sv
module skew_window #(
    parameter int MF_LEN_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                arm,
    input  logic [MF_LEN_W-1:0] mf_len,
    output logic                expired
);
    typedef struct packed {
        logic                active;
        logic [MF_LEN_W-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        expired = win_q.active && (win_q.cnt >= mf_len);
        win_d   = win_q;
        if (clear) begin
            win_d = '0;
        end else if (win_q.active) begin
            if (win_q.cnt != '1) win_d.cnt = win_q.cnt + MF_LEN_W'(1);
        end else if (arm) begin
            win_d.active = 1'b1;
            win_d.cnt    = MF_LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fs_data,
    input  logic [NUM_LANES-1:0] a_hit,
    input  logic [NUM_LANES-1:0] on_bnd,
    input  logic                 expired,
    output logic                 arm,
    output logic                 release_p,
    output logic                 skew_err,
    output logic                 align_err,
    output logic [NUM_LANES-1:0] slip_lanes
);
    import lane_align_pkg::*;

    typedef struct packed {
        phase_e               phase;
        logic [NUM_LANES-1:0] seen;
        logic                 rel;
        logic                 skew_err;
        logic                 align_err;
        logic [NUM_LANES-1:0] slip;
    } ctrl_t;

    ctrl_t                ctl_d, ctl_q;
    logic [NUM_LANES-1:0] seen_nxt;
    logic [NUM_LANES-1:0] bad_lanes;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rel = 1'b0;
        seen_nxt  = ctl_q.seen | a_hit;
        bad_lanes = a_hit & ~on_bnd;
        arm       = fs_data && (ctl_q.phase == PH_COLLECT) &&
                    (ctl_q.seen == '0) && (a_hit != '0);

        if (!fs_data) begin
            ctl_d = '0;
        end else begin
            unique case (ctl_q.phase)
                PH_COLLECT: begin
                    if (expired && (ctl_q.seen != '1)) begin
                        ctl_d.skew_err = 1'b1;
                        ctl_d.phase    = PH_FAIL;
                    end else begin
                        ctl_d.seen = seen_nxt;
                        if (seen_nxt == '1) begin
                            ctl_d.rel   = 1'b1;
                            ctl_d.phase = PH_DATA;
                        end
                    end
                end
                PH_DATA: begin
                    if (bad_lanes != '0) begin
                        ctl_d.align_err = 1'b1;
                        ctl_d.slip      = ctl_q.slip | bad_lanes;
                    end
                end
                default: ; // PH_FAIL holds until frame sync drops
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign release_p  = ctl_q.rel;
    assign skew_err   = ctl_q.skew_err;
    assign align_err  = ctl_q.align_err;
    assign slip_lanes = ctl_q.slip;

endmodule

// File: rtl/lane_align_monitor.sv
module lane_align_monitor #(
    parameter int NUM_LANES = 4,
    parameter int OCTET_W   = 8,
    parameter int MF_LEN_W  = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fs_data_i,
    input  logic [NUM_LANES*OCTET_W-1:0]   lane_octet_i,
    input  logic [NUM_LANES-1:0]           lane_is_k_i,
    input  logic [MF_LEN_W-1:0]            mf_len_i,
    output logic                           release_o,
    output logic                           skew_err_o,
    output logic                           align_err_o,
    output logic [NUM_LANES-1:0]           slip_lanes_o
);
    logic [NUM_LANES-1:0] a_hit;
    logic [NUM_LANES-1:0] on_bnd;
    logic                 arm;
    logic                 expired;
    logic                 clear;

    assign clear = !fs_data_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_mf_tracker #(
            .OCTET_W  (OCTET_W),
            .MF_LEN_W (MF_LEN_W)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear),
            .octet  (lane_octet_i[g*OCTET_W +: OCTET_W]),
            .is_k   (lane_is_k_i[g]),
            .mf_len (mf_len_i),
            .a_hit  (a_hit[g]),
            .on_bnd (on_bnd[g])
        );
    end

    skew_window #(
        .MF_LEN_W (MF_LEN_W)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .arm     (arm),
        .mf_len  (mf_len_i),
        .expired (expired)
    );

    align_ctrl #(
        .NUM_LANES (NUM_LANES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_data    (fs_data_i),
        .a_hit      (a_hit),
        .on_bnd     (on_bnd),
        .expired    (expired),
        .arm        (arm),
        .release_p  (release_o),
        .skew_err   (skew_err_o),
        .align_err  (align_err_o),
        .slip_lanes (slip_lanes_o)
    );

endmodule

// File: rtl/lane_align_checker.sv
module lane_align_checker #(
    parameter int NUM_LANES = 4,
    parameter int OCTET_W   = 8,
    parameter int MF_LEN_W  = 9
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         fs_data_i,
    input logic [NUM_LANES*OCTET_W-1:0] lane_octet_i,
    input logic [NUM_LANES-1:0]         lane_is_k_i,
    input logic [MF_LEN_W-1:0]          mf_len_i,
    input logic                         release_o,
    input logic                         skew_err_o,
    input logic                         align_err_o,
    input logic [NUM_LANES-1:0]         slip_lanes_o
);
    logic any_marker;

    always_comb begin
        any_marker = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (lane_is_k_i[i] && lane_octet_i[i*OCTET_W +: OCTET_W] == OCTET_W'(8'h7C))
                any_marker = 1'b1;
        end
    end

    assert_idle_no_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_data_i |=> !release_o);

    assert_release_needs_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> $past(any_marker && fs_data_i));

    assert_release_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o);

    assert_skew_excludes_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        skew_err_o |-> !release_o);

    assert_slip_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_data_i && slip_lanes_o != '0) |=> ((slip_lanes_o & $past(slip_lanes_o)) == $past(slip_lanes_o)));

    assert_skew_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_data_i && skew_err_o) |=> skew_err_o);

    assert_align_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(align_err_o) |-> $past(!fs_data_i));

endmodule

bind lane_align_monitor lane_align_checker #(
    .NUM_LANES (NUM_LANES),
    .OCTET_W   (OCTET_W),
    .MF_LEN_W  (MF_LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fs_data_i    (fs_data_i),
    .lane_octet_i (lane_octet_i),
    .lane_is_k_i  (lane_is_k_i),
    .mf_len_i     (mf_len_i),
    .release_o    (release_o),
    .skew_err_o   (skew_err_o),
    .align_err_o  (align_err_o),
    .slip_lanes_o (slip_lanes_o)
);

// File: tb/tb_lane_align_monitor.sv
`timescale 1ns/1ps
module tb_lane_align_monitor;
    localparam int NL    = 4;
    localparam int OW    = 8;
    localparam int MW    = 9;
    localparam int START = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              fs_data;
    logic [NL*OW-1:0]  octets;
    logic [NL-1:0]     is_k;
    logic [MW-1:0]     mf_len;
    logic              release_w;
    logic              skew_err;
    logic              align_err;
    logic [NL-1:0]     slip_lanes;

    always #10 clk = ~clk; // 50 MHz

    lane_align_monitor #(.NUM_LANES(NL), .OCTET_W(OW), .MF_LEN_W(MW)) dut (
        .clk(clk), .rst_n(rst_n), .fs_data_i(fs_data),
        .lane_octet_i(octets), .lane_is_k_i(is_k), .mf_len_i(mf_len),
        .release_o(release_w), .skew_err_o(skew_err),
        .align_err_o(align_err), .slip_lanes_o(slip_lanes)
    );

    int n_checks = 0;
    int n_errors = 0;
    int dly[NL];
    int mf;
    int slip_lane;
    int slip_at;
    int obs_rel_cyc, obs_rel_cnt, obs_skew_cyc, obs_align_cyc;
    int exp_rel_cyc, exp_skew_cyc, exp_align_cyc;
    logic [NL-1:0] obs_mask, exp_mask;
    logic end_skew;
    bit low_ok;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int cycles);
        int mn, mx;
        int last_a[NL];
        mn = dly[0]; mx = dly[0];
        for (int l = 0; l < NL; l++) begin
            if (dly[l] < mn) mn = dly[l];
            if (dly[l] > mx) mx = dly[l];
            last_a[l] = -1;
        end
        exp_rel_cyc   = (mx - mn < mf) ? START + mx : -1;
        exp_skew_cyc  = (mx - mn >= mf) ? START + mn + mf : -1;
        exp_align_cyc = -1;
        exp_mask      = '0;
        mf_len        = MW'(mf);

        // new sequence: frame sync low with markers present (R1)
        low_ok  = 1'b1;
        fs_data = 1'b0;
        for (int i = 0; i < 3; i++) begin
            for (int l = 0; l < NL; l++) begin
                octets[l*OW +: OW] = 8'h7C;
                is_k[l] = 1'b1;
            end
            @(posedge clk); #1;
            if (release_w || skew_err || align_err || slip_lanes != '0) low_ok = 1'b0;
        end
        check(low_ok, "R1", "outputs quiet while frame sync low", int'(low_ok), 1);
        check(low_ok, "R6", "flags cleared by frame sync low", int'(low_ok), 1);

        obs_rel_cyc = -1; obs_rel_cnt = 0; obs_skew_cyc = -1; obs_align_cyc = -1;
        fs_data = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            for (int l = 0; l < NL; l++) begin
                int eff, rel;
                bit a;
                eff = dly[l] + ((l == slip_lane && c >= slip_at) ? 1 : 0);
                rel = c - START - eff;
                a   = (c >= START) && (rel >= 0) && (rel % mf == 0);
                if (a) begin
                    octets[l*OW +: OW] = 8'h7C; is_k[l] = 1'b1;
                    if (exp_rel_cyc >= 0 && c > exp_rel_cyc && last_a[l] >= 0 &&
                        c - last_a[l] != mf) begin
                        if (exp_align_cyc < 0) exp_align_cyc = c;
                        exp_mask[l] = 1'b1;
                    end
                    last_a[l] = c;
                end else if (c < START) begin
                    // lookalikes: 7C without control flag, or another control code
                    octets[l*OW +: OW] = (c % 2 == 0) ? 8'h7C : 8'hBC;
                    is_k[l] = (c % 2 != 0);
                end else begin
                    octets[l*OW +: OW] = 8'h20 + OW'(l); is_k[l] = 1'b0;
                end
            end
            @(posedge clk); #1;
            if (release_w) begin
                obs_rel_cnt++;
                if (obs_rel_cyc < 0) obs_rel_cyc = c;
            end
            if (skew_err && obs_skew_cyc < 0) obs_skew_cyc = c;
            if (align_err && obs_align_cyc < 0) obs_align_cyc = c;
        end
        obs_mask = slip_lanes;
        end_skew = skew_err;
    endtask

    task automatic check_results(input string name);
        check(obs_rel_cnt == ((exp_rel_cyc >= 0) ? 1 : 0), "R3",
              {name, " release pulse count"}, obs_rel_cnt, (exp_rel_cyc >= 0) ? 1 : 0);
        check(obs_rel_cyc == exp_rel_cyc, "R3", {name, " release cycle"}, obs_rel_cyc, exp_rel_cyc);
        check(obs_skew_cyc == exp_skew_cyc, "R4", {name, " skew error cycle"}, obs_skew_cyc, exp_skew_cyc);
        check(obs_align_cyc == exp_align_cyc, "R5", {name, " slip error cycle"}, obs_align_cyc, exp_align_cyc);
        check(obs_mask == exp_mask, "R5", {name, " slipped lane mask"}, int'(obs_mask), int'(exp_mask));
    endtask

    task automatic t_reset;
        check(!release_w && !skew_err && !align_err && slip_lanes == '0, "R1",
              "outputs after reset", int'({release_w, skew_err, align_err, slip_lanes}), 0);
    endtask

    task automatic t_aligned;
        mf = 32; dly = '{0, 0, 0, 0}; slip_lane = -1; slip_at = 0;
        run_case(200);
        check_results("aligned");
        check(obs_rel_cyc >= START, "R2", "lookalike characters started nothing", obs_rel_cyc, START);
    endtask

    task automatic t_skewed;
        mf = 16; dly = '{3, 0, 9, 5}; slip_lane = -1; slip_at = 0;
        run_case(150);
        check_results("mixed skew");
    endtask

    task automatic t_edge_ok;
        mf = 16; dly = '{0, 15, 4, 8}; slip_lane = -1; slip_at = 0;
        run_case(150);
        check_results("skew one below multiframe");
    endtask

    task automatic t_edge_bad;
        mf = 16; dly = '{0, 16, 2, 2}; slip_lane = -1; slip_at = 0;
        run_case(150);
        check_results("skew equal to multiframe");
        check(end_skew == 1'b1, "R6", "skew error held", int'(end_skew), 1);
    endtask

    task automatic t_far_skew;
        mf = 8; dly = '{5, 5, 5, 20}; slip_lane = -1; slip_at = 0;
        run_case(80);
        check_results("one lane far late");
    endtask

    task automatic t_slip;
        mf = 20; dly = '{1, 4, 0, 2}; slip_lane = 2; slip_at = START + 50;
        run_case(200);
        check_results("mid-data slip");
        check(obs_mask == 4'b0100, "R5", "only slipped lane flagged", int'(obs_mask), 4);
    endtask

    task automatic t_big;
        mf = 256; dly = '{0, 255, 100, 3}; slip_lane = 1; slip_at = START + 700;
        run_case(1100);
        check_results("multiframe 256 R7");
        check(obs_rel_cyc == START + 255, "R7", "release at widest multiframe", obs_rel_cyc, START + 255);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; fs_data = 1'b0; octets = '0; is_k = '0; mf_len = MW'(16);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_aligned();
        t_skewed();
        t_edge_ok();
        t_edge_bad();
        t_far_skew();
        t_slip();
        t_big();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule